// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that uses rotating register windows. A 5-bit register number is turned into a physical storage index through the current window pointer. Numbers 0 to 7 reach eight global registers that every window shares. Numbers 8 to 15 reach the window's outputs. Numbers 16 to 23 reach its private locals. Numbers 24 to 31 reach its inputs. The output set of one window is the same physical storage as the input set of the window one below it. A caller therefore hands values to a callee without any copy.

A save request moves the pointer down by one window and a restore request moves it up by one, with wrap-around in both cases. Each window has a bit in an invalid mask. When the window that a request would move to is marked invalid, the block raises an overflow flag (for a save) or an underflow flag (for a restore) in the same cycle, and the pointer stays where it is. Software that handles the condition can load the pointer and the mask directly through a control port. The block has two combinational read ports and one write port. A read that hits the physical register being written in the same cycle returns the new data.

Top module: `winreg_file`

## Requirements
- R1: Register numbers 1 to 7 select global registers that give the same value whatever the window pointer is.
- R2: Register number 0 always reads as zero on both read ports, and a write to it changes nothing.
- R3: A save request with the target window valid lowers `cwp_o` by one modulo NWIN at the next clock edge.
- R4: A restore request with the target window valid raises `cwp_o` by one modulo NWIN at the next clock edge.
- R5: In `wim_o`, bit w set to 1 marks window w invalid and 0 marks it valid. A save whose target window (cwp-1 mod NWIN) is invalid drives `ovf_o` high in the same cycle and leaves `cwp_o` unchanged.
- R6: A restore whose target window (cwp+1 mod NWIN) is invalid drives `unf_o` high in the same cycle and leaves `cwp_o` unchanged.
- R7: Register numbers 8 to 15 in window w reach the same storage as numbers 24 to 31 (same low three bits) in window (w-1) mod NWIN.
- R8: Register numbers 16 to 31 in window w reach storage of that window alone. Locals 16 to 23 are shared with no other window.
- R9: With `ctl_we_i` high, `cwp_o` and `wim_o` take `ctl_cwp_i` and `ctl_wim_i` at the next edge. This has priority over save and restore, and no flag is raised. Without it the mask holds its value.
- R10: After reset `cwp_o` is 0, `wim_o` has only bit 1 set, and both flags are low.
- R11: A read of the physical register being written in the same cycle returns the write data before the edge.
- R12: Save and restore asserted together are ignored: no flag is raised and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_i | input | 1 | Request to move to the next lower window |
| restore_i | input | 1 | Request to move to the next higher window |
| ctl_we_i | input | 1 | Load pointer and mask from the control inputs |
| ctl_cwp_i | input | log2(NWIN) | Pointer value to load |
| ctl_wim_i | input | NWIN | Mask value to load |
| cwp_o | output | log2(NWIN) | Current window pointer |
| wim_o | output | NWIN | Invalid window mask, 1 = invalid |
| ovf_o | output | 1 | Save blocked by an invalid target window |
| unf_o | output | 1 | Restore blocked by an invalid target window |
| rd_a_addr_i | input | 5 | Read port A register number |
| rd_a_data_o | output | DW | Read port A data |
| rd_b_addr_i | input | 5 | Read port B register number |
| rd_b_data_o | output | DW | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register number |
| wr_data_i | input | DW | Write data |

## Verification
The pointer-step properties assume that a save or restore is seen only when the control load is idle and the other request is absent. They also assume that the control inputs carry a pointer within range. The stimulus drives each request for a single cycle with every other control low, except in the dedicated priority and collision cases. The bypass property assumes that write and read number the same register under the same pointer, which always holds because both ports share one pointer. The bench sweeps every register number in every window of the default eight-window configuration, and it places the invalid bit at every position for both directions.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  localparam int unsigned REG_AW  = 5;
  localparam int unsigned GRP_SZ  = 8;
  localparam int unsigned WIN_SZ  = 16;

  // Upper two bits of an architectural register number select its group.
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

endpackage

// File: rtl/winreg_map.sv
module winreg_map
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = 3,
  parameter int unsigned IW   = 8
) (
  input  logic [REG_AW-1:0] arch_i,
  input  logic [PW-1:0]     cwp_i,
  output logic [IW-1:0]     phys_o
);

  reg_grp_e     grp;
  logic [PW-1:0] win_sel;
  logic          upper_half;

  // Physical layout: globals at 0..7, then per window 8 locals followed by 8 ins.
  always_comb begin
    grp        = reg_grp_e'(arch_i[4:3]);
    win_sel    = cwp_i;
    upper_half = 1'b1;
    phys_o     = IW'(arch_i[2:0]);
    unique case (grp)
      GRP_GLOBAL: phys_o = IW'(arch_i[2:0]);
      GRP_OUT: begin
        win_sel    = cwp_i - PW'(1);
        upper_half = 1'b1;
        phys_o     = IW'({win_sel, upper_half, arch_i[2:0]}) + IW'(GRP_SZ);
      end
      GRP_LOCAL: begin
        upper_half = 1'b0;
        phys_o     = IW'({win_sel, upper_half, arch_i[2:0]}) + IW'(GRP_SZ);
      end
      GRP_IN: begin
        upper_half = 1'b1;
        phys_o     = IW'({win_sel, upper_half, arch_i[2:0]}) + IW'(GRP_SZ);
      end
      default: phys_o = '0;
    endcase
  end

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            ctl_we_i,
  input  logic [PW-1:0]   ctl_cwp_i,
  input  logic [NWIN-1:0] ctl_wim_i,
  output logic [PW-1:0]   cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            ovf_o,
  output logic            unf_o
);

  localparam logic [NWIN-1:0] WIM_RST = NWIN'(2);

  logic [PW-1:0]   cwp_q, cwp_d, save_tgt, rest_tgt;
  logic [NWIN-1:0] wim_q, wim_d;
  logic            cwp_en, wim_en, ovf, unf;

  always_comb begin
    save_tgt = cwp_q - PW'(1);
    rest_tgt = cwp_q + PW'(1);
    cwp_d    = cwp_q;
    wim_d    = wim_q;
    cwp_en   = 1'b0;
    wim_en   = 1'b0;
    ovf      = 1'b0;
    unf      = 1'b0;
    if (ctl_we_i) begin
      cwp_d  = ctl_cwp_i;
      wim_d  = ctl_wim_i;
      cwp_en = 1'b1;
      wim_en = 1'b1;
    end else if (save_i && !restore_i) begin
      if (wim_q[save_tgt]) begin
        ovf = 1'b1;
      end else begin
        cwp_d  = save_tgt;
        cwp_en = 1'b1;
      end
    end else if (restore_i && !save_i) begin
      if (wim_q[rest_tgt]) begin
        unf = 1'b1;
      end else begin
        cwp_d  = rest_tgt;
        cwp_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
    end else if (cwp_en) begin
      cwp_q <= cwp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wim_q <= WIM_RST;
    end else if (wim_en) begin
      wim_q <= wim_d;
    end
  end

  assign cwp_o = cwp_q;
  assign wim_o = wim_q;
  assign ovf_o = ovf;
  assign unf_o = unf;

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NPHYS = 136,
  parameter int unsigned IW    = 8,
  parameter int unsigned NRD   = 2
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);

  logic [DW-1:0] mem [NPHYS];
  logic          wr_live;

  assign wr_live = we_i && (waddr_i != '0);

  always_ff @(posedge clk) begin
    if (wr_live) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr_i[p] == '0) begin
        rdata_o[p] = '0;
      end else if (wr_live && (waddr_i == raddr_i[p])) begin
        rdata_o[p] = wdata_i;
      end else begin
        rdata_o[p] = mem[raddr_i[p]];
      end
    end
  end

endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     save_i,
  input  logic                     restore_i,
  input  logic                     ctl_we_i,
  input  logic [$clog2(NWIN)-1:0]  ctl_cwp_i,
  input  logic [NWIN-1:0]          ctl_wim_i,
  output logic [$clog2(NWIN)-1:0]  cwp_o,
  output logic [NWIN-1:0]          wim_o,
  output logic                     ovf_o,
  output logic                     unf_o,
  input  logic [4:0]               rd_a_addr_i,
  output logic [DW-1:0]            rd_a_data_o,
  input  logic [4:0]               rd_b_addr_i,
  output logic [DW-1:0]            rd_b_data_o,
  input  logic                     wr_en_i,
  input  logic [4:0]               wr_addr_i,
  input  logic [DW-1:0]            wr_data_i
);

  localparam int unsigned PW    = $clog2(NWIN);
  localparam int unsigned NPHYS = GRP_SZ + NWIN * WIN_SZ;
  localparam int unsigned IW    = $clog2(NPHYS);
  localparam int unsigned NRD   = 2;
  localparam int unsigned NMAP  = NRD + 1;

  logic [REG_AW-1:0] arch_addr [NMAP];
  logic [IW-1:0]     phys_addr [NMAP];
  logic [IW-1:0]     rd_phys   [NRD];
  logic [DW-1:0]     rd_data   [NRD];

  assign arch_addr[0] = rd_a_addr_i;
  assign arch_addr[1] = rd_b_addr_i;
  assign arch_addr[2] = wr_addr_i;

  winreg_ctrl #(.NWIN(NWIN), .PW(PW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .save_i    (save_i),
    .restore_i (restore_i),
    .ctl_we_i  (ctl_we_i),
    .ctl_cwp_i (ctl_cwp_i),
    .ctl_wim_i (ctl_wim_i),
    .cwp_o     (cwp_o),
    .wim_o     (wim_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    winreg_map #(.NWIN(NWIN), .PW(PW), .IW(IW)) map_i (
      .arch_i (arch_addr[m]),
      .cwp_i  (cwp_o),
      .phys_o (phys_addr[m])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rdp
    assign rd_phys[p] = phys_addr[p];
  end

  winreg_bank #(.DW(DW), .NPHYS(NPHYS), .IW(IW), .NRD(NRD)) bank_i (
    .clk     (clk),
    .we_i    (wr_en_i),
    .waddr_i (phys_addr[NRD]),
    .wdata_i (wr_data_i),
    .raddr_i (rd_phys),
    .rdata_o (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    save_i,
  input logic                    restore_i,
  input logic                    ctl_we_i,
  input logic [$clog2(NWIN)-1:0] ctl_cwp_i,
  input logic [NWIN-1:0]         ctl_wim_i,
  input logic [$clog2(NWIN)-1:0] cwp_o,
  input logic [NWIN-1:0]         wim_o,
  input logic                    ovf_o,
  input logic                    unf_o,
  input logic [4:0]              rd_a_addr_i,
  input logic [DW-1:0]           rd_a_data_o,
  input logic                    wr_en_i,
  input logic [4:0]              wr_addr_i,
  input logic [DW-1:0]           wr_data_i
);

  localparam int unsigned PW = $clog2(NWIN);

  AST_G0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr_i == 5'd0) |-> (rd_a_data_o == '0)); // R2

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && !restore_i && !ctl_we_i && !ovf_o) |=> (cwp_o == $past(cwp_o) - PW'(1))); // R3

  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !save_i && !ctl_we_i && !unf_o) |=> (cwp_o == $past(cwp_o) + PW'(1))); // R4

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> $stable(cwp_o)); // R5

  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> $stable(cwp_o)); // R6

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> (cwp_o == $past(ctl_cwp_i)) && (wim_o == $past(ctl_wim_i))); // R9

  AST_CTL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |-> (!ovf_o && !unf_o)); // R9

  AST_WIM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we_i |=> $stable(wim_o)); // R9

  AST_BOTH_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |-> (!ovf_o && !unf_o)); // R12

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i && !ctl_we_i) |=> $stable(cwp_o)); // R12

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == rd_a_addr_i && wr_addr_i != 5'd0) |-> (rd_a_data_o == wr_data_i)); // R11

endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .save_i      (save_i),
  .restore_i   (restore_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_cwp_i   (ctl_cwp_i),
  .ctl_wim_i   (ctl_wim_i),
  .cwp_o       (cwp_o),
  .wim_o       (wim_o),
  .ovf_o       (ovf_o),
  .unf_o       (unf_o),
  .rd_a_addr_i (rd_a_addr_i),
  .rd_a_data_o (rd_a_data_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i)
);

// File: tb/winreg_file_tb.sv
module winreg_file_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NWIN       = 8;
  localparam int PW         = 3;
  localparam int DW         = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            save_i, restore_i, ctl_we_i, wr_en_i;
  logic [PW-1:0]   ctl_cwp_i, cwp_o;
  logic [NWIN-1:0] ctl_wim_i, wim_o;
  logic            ovf_o, unf_o;
  logic [4:0]      rd_a_addr_i, rd_b_addr_i, wr_addr_i;
  logic [DW-1:0]   rd_a_data_o, rd_b_data_o, wr_data_i;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winreg_file #(.NWIN(NWIN), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
    .ctl_we_i(ctl_we_i), .ctl_cwp_i(ctl_cwp_i), .ctl_wim_i(ctl_wim_i),
    .cwp_o(cwp_o), .wim_o(wim_o), .ovf_o(ovf_o), .unf_o(unf_o),
    .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wval(input int w, input int r);
    return {8'hA5, 8'(w), 8'(r), 8'h3C};
  endfunction

  function automatic logic [DW-1:0] gval(input int r);
    return {8'h6E, 16'h0000, 8'(r)};
  endfunction

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl_set(input int c, input logic [NWIN-1:0] m);
    ctl_we_i = 1'b1; ctl_cwp_i = PW'(c); ctl_wim_i = m;
    edge_step();
    ctl_we_i = 1'b0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = d;
    edge_step();
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
    rd_a_addr_i = 5'(a); rd_b_addr_i = 5'(a);
    #1;
    check({req, " port A"}, rd_a_data_o, exp);
    check({req, " port B"}, rd_b_data_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int exp_cwp;
    rst_n = 1'b0; save_i = 0; restore_i = 0; ctl_we_i = 0; wr_en_i = 0;
    ctl_cwp_i = '0; ctl_wim_i = '0; rd_a_addr_i = '0; rd_b_addr_i = '0;
    wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    edge_step();

    // R10 reset state
    check("R10 cwp", DW'(cwp_o), 0);
    check("R10 wim", DW'(wim_o), 32'h2);
    check("R10 ovf", DW'(ovf_o), 0);
    check("R10 unf", DW'(unf_o), 0);

    // Fill locals and ins of every window, then globals from window 3
    for (int w = 0; w < NWIN; w++) begin
      ctl_set(w, '0);
      for (int r = 16; r < 32; r++) wr(r, wval(w, r));
    end
    ctl_set(3, '0);
    for (int r = 1; r < 8; r++) wr(r, gval(r));

    // R2 write to register 0 is discarded
    wr(0, 32'hDEAD_BEEF);
    rd_chk("R2 g0 after write", 0, '0);
    wr_en_i = 1'b1; wr_addr_i = 5'd0; wr_data_i = 32'h1111_2222;
    rd_chk("R2 g0 during write", 0, '0);
    edge_step();
    wr_en_i = 1'b0;

    // R1 R7 R8 full sweep of every register number in every window
    for (int w = 0; w < NWIN; w++) begin
      ctl_set(w, '0);
      for (int r = 0; r < 32; r++) begin
        if (r == 0)       rd_chk("R2 g0 read", r, '0);
        else if (r < 8)   rd_chk("R1 global", r, gval(r));
        else if (r < 16)  rd_chk("R7 out aliases lower in", r, wval((w + NWIN - 1) % NWIN, r + 16));
        else              rd_chk("R8 window private", r, wval(w, r));
      end
    end

    // R3 saves around the ring, R4 restores around the ring
    ctl_set(0, '0);
    exp_cwp = 0;
    for (int i = 0; i < NWIN; i++) begin
      save_i = 1'b1; #1;
      check("R3 no ovf", DW'(ovf_o), 0);
      edge_step(); save_i = 1'b0;
      exp_cwp = (exp_cwp + NWIN - 1) % NWIN;
      check("R3 cwp step", DW'(cwp_o), DW'(exp_cwp));
    end
    for (int i = 0; i < NWIN; i++) begin
      restore_i = 1'b1; #1;
      check("R4 no unf", DW'(unf_o), 0);
      edge_step(); restore_i = 1'b0;
      exp_cwp = (exp_cwp + 1) % NWIN;
      check("R4 cwp step", DW'(cwp_o), DW'(exp_cwp));
    end

    // R5 R6 invalid bit at every position
    for (int v = 0; v < NWIN; v++) begin
      ctl_set((v + 1) % NWIN, NWIN'(1) << v);
      save_i = 1'b1; #1;
      check("R5 ovf", DW'(ovf_o), 1);
      check("R5 no unf", DW'(unf_o), 0);
      edge_step(); save_i = 1'b0;
      check("R5 cwp held", DW'(cwp_o), DW'((v + 1) % NWIN));
      #1 check("R5 ovf drops", DW'(ovf_o), 0);

      ctl_set((v + NWIN - 1) % NWIN, NWIN'(1) << v);
      restore_i = 1'b1; #1;
      check("R6 unf", DW'(unf_o), 1);
      check("R6 no ovf", DW'(ovf_o), 0);
      edge_step(); restore_i = 1'b0;
      check("R6 cwp held", DW'(cwp_o), DW'((v + NWIN - 1) % NWIN));

      ctl_set((v + 1) % NWIN, NWIN'(1) << ((v + 3) % NWIN));
      save_i = 1'b1; #1;
      check("R5 valid target no ovf", DW'(ovf_o), 0);
      edge_step(); save_i = 1'b0;
      check("R5 valid target moves", DW'(cwp_o), DW'(v));
    end

    // R9 control load beats a save to an invalid target
    ctl_set(2, 8'h02);
    ctl_we_i = 1'b1; ctl_cwp_i = 3'd5; ctl_wim_i = 8'h81; save_i = 1'b1; #1;
    check("R9 no flag on load", DW'(ovf_o), 0);
    edge_step(); ctl_we_i = 1'b0; save_i = 1'b0;
    check("R9 cwp loaded", DW'(cwp_o), 5);
    check("R9 wim loaded", DW'(wim_o), 32'h81);
    restore_i = 1'b1; edge_step(); restore_i = 1'b0;
    check("R9 wim kept", DW'(wim_o), 32'h81);

    // R12 simultaneous requests with both targets invalid
    ctl_set(2, 8'h0A);
    save_i = 1'b1; restore_i = 1'b1; #1;
    check("R12 no ovf", DW'(ovf_o), 0);
    check("R12 no unf", DW'(unf_o), 0);
    edge_step(); save_i = 1'b0; restore_i = 1'b0;
    check("R12 cwp held", DW'(cwp_o), 2);

    // R11 same-cycle bypass on port A, port B unaffected
    ctl_set(4, '0);
    wr_en_i = 1'b1; wr_addr_i = 5'd20; wr_data_i = 32'h1234_5678;
    rd_a_addr_i = 5'd20; rd_b_addr_i = 5'd21; #1;
    check("R11 bypass", rd_a_data_o, 32'h1234_5678);
    check("R11 other reg", rd_b_data_o, wval(4, 21));
    edge_step(); wr_en_i = 1'b0; #1;
    check("R11 stored", rd_a_data_o, 32'h1234_5678);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule